// File: doc/BRIEF.md
# Pixel Configuration Shift Register

This block stores the per-pixel setup word of a detector pixel. The setup is eleven bits: two four-bit trim codes for the offset-correction DACs of the lower and upper threshold comparators, and a three-bit test mode. Bits enter serially through a flip-flop chain that advances only on clock edges where the shift enable is high. The last stage of the chain drives a serial output, so the pixels of a column can be daisy chained.

A separate bank of holding registers drives the pixel. It takes a copy of the whole chain only on an edge where the load strobe is high. This means a new setup can be shifted through a column while every pixel keeps its current trims and mode. A decoder turns the held mode into one-hot control lines for the pixel's test switches. One of those lines turns the pixel off.

Top module: `pixcfg_reg`

## Requirements
- R1: The word is {upper trim[3:0], lower trim[3:0], mode[2:0]}. The first bit shifted in ends up as upper trim bit 3 and the eleventh bit as mode bit 0. After eleven enabled shifts and a load, `trim_hi` and `trim_lo` show the shifted values.
- R2: The chain advances only on a rising edge with `shift_en`=1. With `shift_en`=0 the chain and `ser_out` hold, whatever `ser_in` does.
- R3: `ser_out` is the bit that entered `ser_in` eleven enabled shifts earlier, or 0 if fewer than eleven enabled shifts have happened since reset.
- R4: The held outputs change only on an edge with `load`=1. That edge copies the chain as it stood before the edge, including when `shift_en` is also 1 on the same edge.
- R5: Synchronous `rst`=1 clears both the chain and the holding bank. After reset both trims are 0, all control lines are 0 (normal mode) and `ser_out` is 0.
- R6: Held modes 000, 101 and 110 select normal operation: `aout_en`, `tin_en`, `cal_lo_sel`, `cal_hi_sel` and `pix_off` are all 0.
- R7: Held mode 001 drives only `aout_en` high (analog monitor output).
- R8: Held mode 010 drives only `tin_en` high (test charge injection with the counter connected).
- R9: Held mode 011 drives only `cal_lo_sel` high. Held mode 100 drives only `cal_hi_sel` high.
- R10: Held mode 111 drives only `pix_off` high. At no time is more than one control line high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Serial/system clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_in | input | 1 | Serial configuration data |
| shift_en | input | 1 | Advances the chain by one bit |
| load | input | 1 | Copies the chain into the holding bank |
| ser_out | output | 1 | Last chain stage, for daisy chaining |
| trim_lo | output | 4 | Held lower-threshold trim code |
| trim_hi | output | 4 | Held upper-threshold trim code |
| aout_en | output | 1 | Analog monitor output enable |
| tin_en | output | 1 | Test input enable, counter connected |
| cal_lo_sel | output | 1 | Lower-threshold DAC calibration select |
| cal_hi_sel | output | 1 | Upper-threshold DAC calibration select |
| pix_off | output | 1 | Pixel disabled |

## Verification
The hardest case to reach from the ports is a load strobe on the same edge as a shift. Only the ordering of the two register stages decides whether the bank receives the chain before or after that shift. The stimulus reaches it in two ways. A directed case fills the chain with one word and then loads while shifting the next bit. Random traffic puts loads at arbitrary points in the middle of shifting and stalls the enable at random. Every mode code, including the two unused ones and the disable code, is loaded, and the serial output is compared with the bits shifted eleven steps earlier.

// File: rtl/pixcfg_pkg.sv
package pixcfg_pkg;

    localparam int TRIM_W = 4;
    localparam int MODE_W = 3;
    localparam int CFG_W  = 2 * TRIM_W + MODE_W;
    localparam int CTL_W  = 5;

    typedef enum logic [MODE_W-1:0] {
        MODE_RUN    = 3'b000,
        MODE_ANA    = 3'b001,
        MODE_INJ    = 3'b010,
        MODE_CAL_LO = 3'b011,
        MODE_CAL_HI = 3'b100,
        MODE_SPARE5 = 3'b101,
        MODE_SPARE6 = 3'b110,
        MODE_OFF    = 3'b111
    } mode_e;

    // packed MSB first: the first serial bit lands in hi_trim[3]
    typedef struct packed {
        logic [TRIM_W-1:0] hi_trim;
        logic [TRIM_W-1:0] lo_trim;
        logic [MODE_W-1:0] mode;
    } cfg_word_t;

    typedef struct packed {
        logic aout_en;
        logic tin_en;
        logic cal_lo;
        logic cal_hi;
        logic off;
    } pix_ctl_t;

    function automatic pix_ctl_t decode_mode(input logic [MODE_W-1:0] bits);
        pix_ctl_t c;
        c = '0;
        case (mode_e'(bits))
            MODE_ANA:    c.aout_en = 1'b1;
            MODE_INJ:    c.tin_en  = 1'b1;
            MODE_CAL_LO: c.cal_lo  = 1'b1;
            MODE_CAL_HI: c.cal_hi  = 1'b1;
            MODE_OFF:    c.off     = 1'b1;
            default:     c = '0;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/pixcfg_chain.sv
module pixcfg_chain #(
    parameter int W = pixcfg_pkg::CFG_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  logic         din,
    output logic [W-1:0] q
);
    // stage 0 takes the serial input, higher stages take their lower neighbour
    for (genvar i = 0; i < W; i++) begin : g_stage
        logic d;
        if (i == 0) begin : g_head
            assign d = din;
        end else begin : g_body
            assign d = q[i-1];
        end
        always_ff @(posedge clk) begin
            if (rst)     q[i] <= 1'b0;
            else if (en) q[i] <= d;
        end
    end
endmodule

// File: rtl/pixcfg_hold.sv
module pixcfg_hold #(
    parameter int W = pixcfg_pkg::CFG_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst)       q <= '0;
        else if (load) q <= d;
    end
endmodule

// File: rtl/pixcfg_mode_dec.sv
module pixcfg_mode_dec
    import pixcfg_pkg::*;
(
    input  logic [MODE_W-1:0] mode,
    output pix_ctl_t          ctl
);
    always_comb ctl = decode_mode(mode);
endmodule

// File: rtl/pixcfg_reg.sv
module pixcfg_reg
    import pixcfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ser_in,
    input  logic              shift_en,
    input  logic              load,
    output logic              ser_out,
    output logic [TRIM_W-1:0] trim_lo,
    output logic [TRIM_W-1:0] trim_hi,
    output logic              aout_en,
    output logic              tin_en,
    output logic              cal_lo_sel,
    output logic              cal_hi_sel,
    output logic              pix_off
);
    logic [CFG_W-1:0] chain_q;
    logic [CFG_W-1:0] held_q;
    cfg_word_t        held;
    pix_ctl_t         ctl;

    pixcfg_chain #(.W(CFG_W)) u_chain (
        .clk (clk),
        .rst (rst),
        .en  (shift_en),
        .din (ser_in),
        .q   (chain_q)
    );

    pixcfg_hold #(.W(CFG_W)) u_hold (
        .clk  (clk),
        .rst  (rst),
        .load (load),
        .d    (chain_q),
        .q    (held_q)
    );

    assign held = cfg_word_t'(held_q);

    pixcfg_mode_dec u_dec (
        .mode (held.mode),
        .ctl  (ctl)
    );

    assign ser_out    = chain_q[CFG_W-1];
    assign trim_hi    = held.hi_trim;
    assign trim_lo    = held.lo_trim;
    assign aout_en    = ctl.aout_en;
    assign tin_en     = ctl.tin_en;
    assign cal_lo_sel = ctl.cal_lo;
    assign cal_hi_sel = ctl.cal_hi;
    assign pix_off    = ctl.off;
endmodule

// File: rtl/pixcfg_reg_chk.sv
module pixcfg_reg_chk
    import pixcfg_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              shift_en,
    input logic              load,
    input logic              ser_out,
    input logic [TRIM_W-1:0] trim_lo,
    input logic [TRIM_W-1:0] trim_hi,
    input logic              aout_en,
    input logic              tin_en,
    input logic              cal_lo_sel,
    input logic              cal_hi_sel,
    input logic              pix_off
);
    logic [CTL_W-1:0] ctl_v;
    assign ctl_v = {aout_en, tin_en, cal_lo_sel, cal_hi_sel, pix_off};

    assert_reset_clear_R5: assert property (@(posedge clk)
        rst |=> (trim_lo == '0 && trim_hi == '0 && ctl_v == '0 && !ser_out));

    assert_hold_stable_R4: assert property (@(posedge clk) disable iff (rst)
        !load |=> ($stable(trim_lo) && $stable(trim_hi) && $stable(ctl_v)));

    assert_sout_hold_R2: assert property (@(posedge clk) disable iff (rst)
        !shift_en |=> $stable(ser_out));

    assert_ctl_onehot_R10: assert property (@(posedge clk) disable iff (rst)
        $onehot0(ctl_v));
endmodule

bind pixcfg_reg pixcfg_reg_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .shift_en   (shift_en),
    .load       (load),
    .ser_out    (ser_out),
    .trim_lo    (trim_lo),
    .trim_hi    (trim_hi),
    .aout_en    (aout_en),
    .tin_en     (tin_en),
    .cal_lo_sel (cal_lo_sel),
    .cal_hi_sel (cal_hi_sel),
    .pix_off    (pix_off)
);

// File: tb/pixcfg_reg_test.sv
module pixcfg_reg_test;
    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic       rst = 1'b1, ser_in = 1'b0, shift_en = 1'b0, load = 1'b0;
    logic       ser_out, aout_en, tin_en, cal_lo_sel, cal_hi_sel, pix_off;
    logic [3:0] trim_lo, trim_hi;

    pixcfg_reg uut (
        .clk(clk), .rst(rst), .ser_in(ser_in), .shift_en(shift_en), .load(load),
        .ser_out(ser_out), .trim_lo(trim_lo), .trim_hi(trim_hi),
        .aout_en(aout_en), .tin_en(tin_en), .cal_lo_sel(cal_lo_sel),
        .cal_hi_sel(cal_hi_sel), .pix_off(pix_off)
    );

    int vectors = 0;
    int errors  = 0;
    logic [10:0] sh   = '0;   // model of the chain
    logic [10:0] held = '0;   // model of the holding bank

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // expected control lines {aout, tin, cal_lo, cal_hi, off}
    function automatic logic [4:0] exp_ctl(input logic [2:0] m);
        case (m)
            3'b001:  return 5'b10000;
            3'b010:  return 5'b01000;
            3'b011:  return 5'b00100;
            3'b100:  return 5'b00010;
            3'b111:  return 5'b00001;
            default: return 5'b00000;
        endcase
    endfunction

    function automatic string mode_tag(input logic [2:0] m);
        case (m)
            3'b001:         return "R7";
            3'b010:         return "R8";
            3'b011, 3'b100: return "R9";
            3'b111:         return "R10";
            default:        return "R6";
        endcase
    endfunction

    task automatic check_outs(input string ttrim, input string tsout);
        chk(ttrim, 32'(trim_hi), 32'(held[10:7]));
        chk(ttrim, 32'(trim_lo), 32'(held[6:3]));
        chk(mode_tag(held[2:0]), 32'({aout_en, tin_en, cal_lo_sel, cal_hi_sel, pix_off}),
            32'(exp_ctl(held[2:0])));
        chk(tsout, 32'(ser_out), 32'(sh[10]));
    endtask

    task automatic cyc(input logic b, input logic en, input logic ld,
                       input string ttrim, input string tsout);
        ser_in = b; shift_en = en; load = ld;
        @(posedge clk);
        if (ld) held = sh;
        if (en) sh = {sh[9:0], b};
        @(negedge clk);
        check_outs(ttrim, tsout);
    endtask

    task automatic send(input logic [10:0] w, input logic ld);
        for (int i = 10; i >= 0; i--) cyc(w[i], 1'b1, 1'b0, "R4", "R3");
        if (ld) cyc(1'b0, 1'b0, 1'b1, "R1", "R2");
    endtask

    task automatic do_reset;
        rst = 1'b1; shift_en = 1'b0; load = 1'b0;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        sh = '0; held = '0;
        check_outs("R5", "R5");
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (2) @(posedge clk);
        @(negedge clk);
        do_reset();

        // every mode with distinct trims (R1, R6..R10)
        for (int m = 0; m < 8; m++) send({4'(m + 3), 4'(12 - m), 3'(m)}, 1'b1);

        // shift stalls with toggling serial input (R2)
        send(11'b1010_0110_111, 1'b0);
        for (int k = 0; k < 6; k++) cyc(k[0], 1'b0, 1'b0, "R4", "R2");
        cyc(1'b0, 1'b0, 1'b1, "R1", "R2");

        // load on the same edge as a shift (R4)
        send(11'b0011_1100_010, 1'b1);
        send(11'b1111_0001_011, 1'b0);
        cyc(1'b1, 1'b1, 1'b1, "R4", "R3");
        cyc(1'b0, 1'b0, 1'b0, "R4", "R2");

        // reset in the middle of shifting clears the chain too (R5)
        for (int k = 0; k < 5; k++) cyc(1'b1, 1'b1, 1'b0, "R4", "R3");
        do_reset();
        cyc(1'b0, 1'b0, 1'b1, "R5", "R5");

        // random traffic: gaps and stray loads
        for (int n = 0; n < 400; n++) begin
            logic b, en, ld;
            b  = 1'($urandom);
            en = ($urandom % 4) != 0;
            ld = ($urandom % 9) == 0;
            cyc(b, en, ld, ld ? "R4" : "R4", en ? "R3" : "R2");
        end
        for (int n = 0; n < 20; n++) send(11'($urandom), 1'b1);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule